// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (Two-Wire)

This block is the serial configuration front end of a multi-output clock generator. It watches a two-wire bus (SCL plus an open-drain SDA), which it samples on the local system clock. It recognises start and stop conditions and decodes byte transfers. It stores an eight-byte register bank that sets which clock outputs run, whether all outputs float, the spread-spectrum mode, and whether the output frequency comes from board straps or from software bits.

A write transaction carries the device address and then two preamble bytes, a command byte and a length byte. The slave acknowledges both and discards their values. Each data byte after them lands in the next register, starting at register 0. A read transaction returns a length byte and then the registers in order. Some bits of the bank are not storage: they reflect inverted strap levels captured when reset is released. Two whole bytes are fixed identification values.

Top module: `clkcfg_twi_top`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal `DEV_ADDR` (default 0x69), with bit 0 giving the direction (0 write, 1 read). It does not acknowledge any other address, and it leaves the bus and the registers untouched until the next start.
- R2: In a write, the two bytes after the address are acknowledged and their values change no register.
- R3: Data bytes after the preamble are each acknowledged and go to registers 0, 1, 2 and on in order. On `regBus`, register i occupies bits 8i+7..8i.
- R4: Data bytes past the eighth are acknowledged and change nothing.
- R5: After reset: register 0 = 0x00, register 2 = 0xFF, register 3 = 0xFF, register 5 = 0x00, register 1 bits 4..0 = 1, and register 4 bits 6, 5, 3, 1, 0 = 1 with bit 4 = 0.
- R6: Register 6 reads 0x92 and register 7 reads 0x02. Writes to them are acknowledged and have no effect.
- R7: Register 1 bits 7, 6, 5 read as the inverted strap levels FS3, FS0, FS2. Register 4 bit 7 reads as the inverted alternate-select strap and bit 4 bit 2 reads as the inverted FS1 strap. Writes do not change these bits. Register 1 bits 4..0 and register 4 bits 6, 5, 4, 3, 1, 0 are writable.
- R8: Strap levels are captured once after reset is released. Later changes on the strap pins affect neither the read-back bits nor the hardware frequency selection.
- R9: When register 0 bit 3 is 0, `freqSel` equals the captured straps {FS3,FS2,FS1,FS0} and `altSel` equals the captured alternate strap. When bit 3 is 1, `freqSel` = {reg0[2], reg0[6:4]} and `altSel` = reg1[1].
- R10: A read returns 0x08 first, then registers 0 to 7, then 0xFF for any further byte. The slave releases SDA once the master answers a byte with NACK.
- R11: A start seen in the middle of a byte abandons that byte and restarts decoding at the address byte. A stop returns the slave to idle with SDA released.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strapFs | input | 4 | Frequency strap pins {FS3,FS2,FS1,FS0} |
| strapAlt | input | 1 | Alternate-select strap pin |
| regBus | output | 64 | Read-back view of registers 0..7, register i in bits 8i+7..8i |
| freqSel | output | 4 | Selected frequency code (strap or software) |
| altSel | output | 1 | Selected alternate-table bit (strap or software) |

## Verification
The properties assume that the master changes SDA only well inside the SCL low phase, and that each SCL phase lasts several system clocks longer than the three-stage input synchroniser. Under that assumption the slave's own SDA edges and register updates always fall while SCL is low. The bench master holds every SCL quarter-phase for four system clocks and moves SDA one quarter after each falling edge. It releases SDA during acknowledge and read phases, so start and stop edges come only from the master's deliberate sequences. Random write lengths, data and preamble values stay inside this bus discipline, and the directed cases cover a foreign address, a length-only write, overlong writes, an aborted byte and both frequency-select sources.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int NREG = 8;            // registers visible on the bus
  localparam int NWR  = 6;            // registers with storage
  localparam int IDXW = $clog2(NREG);
  localparam int CNTW = 4;            // byte / transmit counters
  localparam int PRE  = 3;            // address + command + length
  localparam logic [7:0] ID_HI = 8'h92;
  localparam logic [7:0] ID_LO = 8'h02;

  typedef struct packed {
    logic            wrEn;
    logic [IDXW-1:0] wrIdx;
    logic [7:0]      wrData;
    logic [CNTW-1:0] txIdx;
  } ctrlStb_t;

  function automatic logic [7:0] wrMask(input int i);
    case (i)
      1:       return 8'h1F;
      4:       return 8'h7B;
      6, 7:    return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] resetVal(input int i);
    case (i)
      1:       return 8'h1F;
      2, 3:    return 8'hFF;
      4:       return 8'h6B;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_link.sv
module clkcfg_link
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output ctrlStb_t   stb,
  output logic       sdaOe
);
  typedef enum logic [2:0] {S_IDLE, S_RECV, S_ACKO, S_SEND, S_ACKI} state_t;
  localparam logic [CNTW-1:0] CMAX   = '1;
  localparam logic [CNTW-1:0] PRE_C  = CNTW'(PRE);
  localparam logic [CNTW-1:0] LAST_C = CNTW'(PRE + NREG);

  state_t          st;
  logic [2:0]      sclSy, sdaSy;
  logic [3:0]      bitCnt;
  logic [7:0]      shReg, txSh;
  logic [CNTW-1:0] byteIdx, txIdx;
  logic            rdMode, nackSeen;
  logic            wrEn;
  logic [IDXW-1:0] wrIdx;
  logic [7:0]      wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSy <= '1;
      sdaSy <= '1;
    end else begin
      sclSy <= {sclSy[1:0], sclIn};
      sdaSy <= {sdaSy[1:0], sdaIn};
    end
  end

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclSy[1] & ~sclSy[2];
  assign sclFall  = ~sclSy[1] & sclSy[2];
  assign startDet = sclSy[1] & sclSy[2] & sdaSy[2] & ~sdaSy[1];
  assign stopDet  = sclSy[1] & sclSy[2] & ~sdaSy[2] & sdaSy[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; bitCnt <= '0; shReg <= '0; txSh <= '0;
      byteIdx <= '0; txIdx <= '0; rdMode <= 1'b0; nackSeen <= 1'b0;
      sdaOe <= 1'b0; wrEn <= 1'b0; wrIdx <= '0; wrData <= '0;
    end else begin
      wrEn <= 1'b0;
      if (startDet) begin
        st <= S_RECV; bitCnt <= '0; byteIdx <= '0; txIdx <= '0;
        rdMode <= 1'b0; sdaOe <= 1'b0;
      end else if (stopDet) begin
        st <= S_IDLE; sdaOe <= 1'b0;
      end else begin
        case (st)
          S_RECV: begin
            if (sclRise && bitCnt < 4'd8) begin
              shReg  <= {shReg[6:0], sdaSy[1]};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (byteIdx == '0) begin
                if (shReg[7:1] == DEV_ADDR) begin
                  rdMode <= shReg[0]; sdaOe <= 1'b1; st <= S_ACKO;
                  byteIdx <= CNTW'(1);
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                sdaOe <= 1'b1; st <= S_ACKO;
                if (byteIdx != CMAX) byteIdx <= byteIdx + CNTW'(1);
                if (byteIdx >= PRE_C && byteIdx < LAST_C) begin
                  wrEn   <= 1'b1;
                  wrIdx  <= IDXW'(byteIdx - PRE_C);
                  wrData <= shReg;
                end
              end
            end
          end
          S_ACKO: if (sclFall) begin
            if (rdMode) begin
              txSh <= rdByte; sdaOe <= ~rdByte[7]; st <= S_SEND; bitCnt <= '0;
            end else begin
              sdaOe <= 1'b0; st <= S_RECV;
            end
          end
          S_SEND: if (sclFall) begin
            if (bitCnt == 4'd7) begin
              sdaOe <= 1'b0; st <= S_ACKI;
            end else begin
              bitCnt <= bitCnt + 4'd1;
              txSh   <= {txSh[6:0], 1'b0};
              sdaOe  <= ~txSh[6];
            end
          end
          S_ACKI: begin
            if (sclRise) begin
              nackSeen <= sdaSy[1];
              if (!sdaSy[1] && txIdx != CMAX) txIdx <= txIdx + CNTW'(1);
            end else if (sclFall) begin
              if (nackSeen) st <= S_IDLE;
              else begin
                txSh <= rdByte; sdaOe <= ~rdByte[7]; st <= S_SEND; bitCnt <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign stb = '{wrEn: wrEn, wrIdx: wrIdx, wrData: wrData, txIdx: txIdx};
endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
  import clkcfg_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStb_t        stb,
  input  logic [3:0]      strapFs,
  input  logic            strapAlt,
  output logic [7:0]      rdByte,
  output logic [8*NREG-1:0] regBus,
  output logic [3:0]      freqSel,
  output logic            altSel
);
  logic [7:0] store [NWR];
  logic [7:0] view  [NREG];
  logic [3:0] fsHeld;
  logic       altHeld, heldOk;

  for (genvar i = 0; i < NWR; i++) begin : g_reg
    localparam logic [7:0] MSK = wrMask(i);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) store[i] <= resetVal(i);
      else if (stb.wrEn && stb.wrIdx == IDXW'(i))
        store[i] <= (store[i] & ~MSK) | (stb.wrData & MSK);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldOk <= 1'b0; fsHeld <= '0; altHeld <= 1'b0;
    end else if (!heldOk) begin
      heldOk <= 1'b1; fsHeld <= strapFs; altHeld <= strapAlt;
    end
  end

  always_comb begin
    for (int i = 0; i < NWR; i++) view[i] = store[i] & wrMask(i);
    view[6] = ID_HI;
    view[7] = ID_LO;
    view[1][7:5] = ~{fsHeld[3], fsHeld[0], fsHeld[2]};
    view[4][7]   = ~altHeld;
    view[4][2]   = ~fsHeld[1];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_bus
    assign regBus[8*i +: 8] = view[i];
  end

  always_comb begin
    if (stb.txIdx == '0)                   rdByte = 8'(NREG);
    else if (stb.txIdx <= CNTW'(NREG))     rdByte = view[IDXW'(stb.txIdx - CNTW'(1))];
    else                                   rdByte = 8'hFF;
  end

  assign freqSel = view[0][3] ? {view[0][2], view[0][6:4]} : fsHeld;
  assign altSel  = view[0][3] ? view[1][1] : altHeld;
endmodule

// File: rtl/clkcfg_twi_top.sv
module clkcfg_twi_top
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  input  logic [3:0]  strapFs,
  input  logic        strapAlt,
  output logic [63:0] regBus,
  output logic [3:0]  freqSel,
  output logic        altSel
);
  ctrlStb_t   stb;
  logic [7:0] rdByte;

  clkcfg_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdByte(rdByte), .stb(stb), .sdaOe(sdaOe)
  );

  clkcfg_bank u_bank (
    .clk(clk), .rstN(rstN), .stb(stb), .strapFs(strapFs), .strapAlt(strapAlt),
    .rdByte(rdByte), .regBus(regBus), .freqSel(freqSel), .altSel(altSel)
  );
endmodule

// File: rtl/clkcfg_twi_chk.sv
module clkcfg_twi_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic        sdaIn,
  input logic        sdaOe,
  input logic [63:0] regBus,
  input logic [3:0]  freqSel
);
  logic [2:0] sclS, sdaS;
  logic [1:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclS <= '1; sdaS <= '1; upCnt <= '0;
    end else begin
      sclS <= {sclS[1:0], sclIn};
      sdaS <= {sdaS[1:0], sdaIn};
      if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
    end
  end

  logic stopSeen;
  assign stopSeen = sclS[1] & sclS[2] & ~sdaS[2] & sdaS[1];

  p_sda_moves_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

  p_strap_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd2) |-> $stable({regBus[15:13], regBus[39], regBus[34]}));

  p_hw_select_fixed_r9: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd2 && !regBus[3] && $past(!regBus[3])) |-> $stable(freqSel));

  p_write_scl_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd2 && !$stable(regBus[47:0])) |-> !sclIn);
endmodule

bind clkcfg_twi_top clkcfg_twi_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaOe(sdaOe),
  .regBus(regBus), .freqSel(freqSel)
);

// File: tb/clkcfg_twi_top_test.sv
module clkcfg_twi_top_test;
  localparam int Q = 4;
  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, sdaDrv = 1'b1;
  logic [3:0] strapFs = 4'b0110;
  logic strapAlt = 1'b1;
  logic sdaOe, altSel, sdaLine;
  logic [63:0] regBus;
  logic [3:0] freqSel;
  assign sdaLine = sdaDrv & ~sdaOe;

  clkcfg_twi_top uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapFs(strapFs), .strapAlt(strapAlt), .regBus(regBus),
    .freqSel(freqSel), .altSel(altSel)
  );

  always #5 clk = ~clk;

  int nRun = 0, nFail = 0;
  bit finished = 1'b0;
  logic [7:0] m [6];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic [3:0] fsL = 4'b0110;
  logic selL = 1'b1;
  bit highMoved;

  function automatic logic [7:0] mskOf(input int i);
    return (i == 1) ? 8'h1F : (i == 4) ? 8'h7B : 8'hFF;
  endfunction

  function automatic logic [7:0] expView(input int i);
    case (i)
      1: return {~fsL[3], ~fsL[0], ~fsL[2], m[1][4:0]};
      4: return {~selL, m[4][6:3], ~fsL[1], m[4][1:0]};
      6: return 8'h92;
      7: return 8'h02;
      default: return m[i];
    endcase
  endfunction

  function automatic logic [63:0] expBus();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = expView(i);
    return v;
  endfunction

  function automatic logic [7:0] expRead(input int k);
    if (k == 0) return 8'h08;
    if (k <= 8) return expView(k - 1);
    return 8'hFF;
  endfunction

  function automatic logic [3:0] expFreq();
    return m[0][3] ? {m[0][2], m[0][6:4]} : fsL;
  endfunction

  function automatic logic expAlt();
    return m[0][3] ? m[1][1] : selL;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wrBit(input logic b);
    sdaDrv = b; waitq(); scl = 1'b1; waitq(); waitq(); scl = 1'b0; waitq();
  endtask

  task automatic rdBit(output logic b);
    logic b0;
    sdaDrv = 1'b1; waitq(); scl = 1'b1; @(negedge clk); b0 = sdaLine;
    repeat (Q - 1) @(negedge clk); b = sdaLine; waitq();
    if (sdaLine != b0 || sdaLine != b) highMoved = 1'b1;
    scl = 1'b0; waitq();
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitq(); scl = 1'b1; waitq(); sdaDrv = 1'b0; waitq(); scl = 1'b0; waitq();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitq(); scl = 1'b1; waitq(); sdaDrv = 1'b1; waitq(); waitq();
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) wrBit(v[i]);
    rdBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rdBit(b); v[i] = b; end
    wrBit(nack);
  endtask

  task automatic doWrite(input int n, output int acks);
    bit a;
    acks = 0;
    busStart();
    sendByte({ADDR, 1'b0}, a); acks += int'(a);
    sendByte(8'($urandom), a); acks += int'(a);
    sendByte(8'($urandom), a); acks += int'(a);
    for (int k = 0; k < n; k++) begin sendByte(wbuf[k], a); acks += int'(a); end
    busStop();
    for (int k = 0; k < n && k < 6; k++) m[k] = (m[k] & ~mskOf(k)) | (wbuf[k] & mskOf(k));
  endtask

  task automatic doRead(input int n, output bit addrAck);
    busStart();
    sendByte({ADDR, 1'b1}, addrAck);
    for (int k = 0; k < n; k++) recvByte(rbuf[k], (k == n - 1));
    busStop();
  endtask

  task automatic checkRead(input int n, input string req);
    bit a;
    int bad = 0;
    int firstBad = 0;
    highMoved = 1'b0;
    doRead(n, a);
    check(a, req, 64'(a), 64'd1);
    for (int k = n - 1; k >= 0; k--) if (rbuf[k] !== expRead(k)) begin bad++; firstBad = k; end
    check(bad == 0, req, 64'(rbuf[firstBad]), 64'(expRead(firstBad)));
    check(!highMoved, "R12 SDA steady while SCL high", 64'(highMoved), 64'd0);
    check(sdaOe == 1'b0, "R10 released after NACK and stop", 64'(sdaOe), 64'd0);
  endtask

  task automatic checkState(input string req);
    check(regBus === expBus(), req, regBus, expBus());
    check(freqSel === expFreq() && altSel === expAlt(), {req, " R9 select"},
          64'({freqSel, altSel}), 64'({expFreq(), expAlt()}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int acks;
    bit a;
    void'($urandom(32'd20240611));
    m[0] = 8'h00; m[1] = 8'h1F; m[2] = 8'hFF; m[3] = 8'hFF; m[4] = 8'h6B; m[5] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R5 R6 R7 reset view, R9 hardware source
    checkState("R5 R6 R7 reset values");
    check(sdaOe == 1'b0, "R5 bus released at reset", 64'(sdaOe), 64'd0);
    // R8 later strap changes ignored
    strapFs = 4'b1001; strapAlt = 1'b0;
    repeat (10) @(negedge clk);
    checkState("R8 straps held");

    // R1 foreign address: no ack, nothing written
    busStart();
    sendByte({7'h2A, 1'b0}, a);
    check(!a, "R1 foreign address not acked", 64'(a), 64'd0);
    sendByte(8'h00, a); sendByte(8'h00, a); sendByte(8'h55, a);
    check(!a, "R1 slave stays off bus", 64'(a), 64'd0);
    busStop();
    checkState("R1 registers untouched");

    // R2 preamble only
    doWrite(0, acks);
    check(acks == 3, "R2 preamble acked", 64'(acks), 64'd3);
    checkState("R2 preamble changes nothing");

    // R3 R4 R6 R7 overlong write
    for (int k = 0; k < 11; k++) wbuf[k] = 8'($urandom);
    wbuf[0] = 8'h00;
    doWrite(11, acks);
    check(acks == 14, "R3 R4 all bytes acked", 64'(acks), 64'd14);
    checkState("R3 R4 R6 R7 sequential fill");

    // R10 read-back
    checkRead(11, "R10 read sequence");

    // R11 aborted byte then repeated start
    busStart();
    sendByte({ADDR, 1'b0}, a); sendByte(8'h11, a); sendByte(8'h22, a);
    wrBit(1'b1); wrBit(1'b0); wrBit(1'b1); wrBit(1'b1);
    wbuf[0] = 8'h81;
    doWrite(1, acks);
    check(acks == 4, "R11 restart acked", 64'(acks), 64'd4);
    checkState("R11 restart writes register 0");

    // R9 software select
    wbuf[0] = 8'h5C; wbuf[1] = 8'h02;
    doWrite(2, acks);
    check(freqSel === 4'b1101 && altSel === 1'b1, "R9 software source",
          64'({freqSel, altSel}), 64'({4'b1101, 1'b1}));
    checkState("R9 software state");

    // random writes with read-back
    for (int it = 0; it < 16; it++) begin
      int n;
      n = int'($urandom_range(0, 10));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      doWrite(n, acks);
      check(acks == n + 3, "R3 random acks", 64'(acks), 64'(n + 3));
      checkState("R3 R6 R7 R9 random state");
      checkRead(int'($urandom_range(1, 11)), "R10 random read");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule